// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches a single asynchronous serial line that has already been brought into the clock domain and measures how long the line keeps one level. From the configured bit period (in clocks) and the frame format (data bit count, optional parity bit, stop length in half-bit steps) it works out the time span of one complete frame in clocks. That span is the yardstick for both events it reports.

A break strobe is raised when the line went low, stayed low for at least one frame span, and then returned high; the strobe is judged at the moment of return. An idle strobe is raised each time the line has stayed high for a whole frame span, so an idle line yields a steady train of idle strobes, one per frame span. An optional inversion is applied to the line before any edge or level is judged. Character decoding is not part of this block; it is meant to sit beside a receiver and feed framing layers that care about line gaps and breaks.

Top module: `uart_line_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it, both break_pulse and idle_pulse are 0.
- R2: The frame span F in clocks is ceil(H × bit_width / 2), with H = 2 × (1 + data_bits + parity_en) + stop_len, where stop_len counts stop time in half bits: 0 = no stop, 1 = half, 2 = one, 3 = one and a half.
- R3: If the line, after a high sample, is low for L consecutive clock samples with L ≥ F and then is sampled high, break_pulse is 1 for exactly one cycle, the cycle after that high sample; the line level at that moment is high.
- R4: A low run of L < F samples followed by a high sample produces no break_pulse.
- R5: A low level present from reset, with no high-to-low transition seen since, produces no break_pulse when the line goes high.
- R6: When the line turns high (or is high after reset), counting that first high sample as index 0, idle_pulse is 1 in the cycle after sample index F.
- R7: While the line stays high, idle_pulse repeats after sample indices 2F, 3F, ... and is 0 elsewhere.
- R8: A low sample cancels the running idle span: no idle_pulse follows a low sample, and the next span counts from the following first high sample.
- R9: With invert_en = 1 the logical level is the complement of line_in, and R3 to R8 hold on that logical level.
- R10: Internal span counters saturate: a low run longer than the counter range still yields exactly one break_pulse on the return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronized serial line |
| invert_en | input | 1 | 1 = complement the line before evaluation |
| bit_width | input | BW_W | Clocks per bit |
| data_bits | input | 4 | Data bits per frame |
| parity_en | input | 1 | 1 = frame carries a parity bit |
| stop_len | input | 2 | Stop time in half bits (0..3) |
| break_pulse | output | 1 | One-cycle strobe: long low period ended |
| idle_pulse | output | 1 | One-cycle strobe: one frame span of steady high |

## Verification
Low runs of F-1, F and F+1 samples separate a correct at-least comparison from an off-by-one or strict one, and a very long low run shows that the low counter saturates instead of wrapping back under F. Long high runs under five frame formats, including an odd half-bit product that needs rounding up, pin down the frame span formula and the idle repetition period. A high run broken by one low sample just before a span completes shows that idle measurement is cancelled, and a low level held from reset shows that a break needs a seen falling edge. The same break and idle patterns are repeated with inversion on.

// File: rtl/uart_lm_pkg.sv
package uart_lm_pkg;

    // Width of the data bit count input.
    localparam int DATA_CNT_W = 4;

    // Width of the frame length in half-bit units: 2*(1+15+1)+3 = 37 fits in 6 bits.
    localparam int HALF_UNITS_W = 6;

    // Stop length codes, counted in half bits.
    localparam logic [1:0] STOP_NONE     = 2'd0;
    localparam logic [1:0] STOP_HALF     = 2'd1;
    localparam logic [1:0] STOP_ONE      = 2'd2;
    localparam logic [1:0] STOP_ONE_HALF = 2'd3;

endpackage

// File: rtl/ulm_frame_len.sv
module ulm_frame_len
    import uart_lm_pkg::*;
#(
    parameter int BW_W = 16,
    parameter int FL_W = BW_W + HALF_UNITS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BW_W-1:0]       bit_width,
    input  logic [DATA_CNT_W-1:0] data_bits,
    input  logic                  parity_en,
    input  logic [1:0]            stop_len,
    output logic [FL_W-1:0]       frame_len
);

    localparam int PW = HALF_UNITS_W + BW_W;

    logic [HALF_UNITS_W-1:0] halves;
    logic [PW-1:0]           prod;
    logic [PW:0]             rounded;
    logic [FL_W-1:0]         fl_d, fl_q;

    always_comb begin
        halves  = HALF_UNITS_W'(2) * (HALF_UNITS_W'(1) + HALF_UNITS_W'(data_bits)
                                      + HALF_UNITS_W'(parity_en))
                  + HALF_UNITS_W'(stop_len);
        prod    = PW'(halves) * PW'(bit_width);
        rounded = ({1'b0, prod} + (PW+1)'(1)) >> 1;
        fl_d    = FL_W'(rounded);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign frame_len = fl_q;

endmodule

// File: rtl/ulm_line_cond.sv
module ulm_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert_en,
    output logic level,
    output logic level_q,
    output logic fall,
    output logic rise
);

    typedef struct packed {
        logic primed;
        logic lvl;
    } cond_t;

    cond_t s_d, s_q;

    always_comb begin
        level      = line_in ^ invert_en;
        s_d.primed = 1'b1;
        s_d.lvl    = level;
        fall       = s_q.primed &  s_q.lvl & ~level;
        rise       = s_q.primed & ~s_q.lvl &  level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{primed: 1'b0, lvl: 1'b1};
        else        s_q <= s_d;
    end

    assign level_q = s_q.lvl;

endmodule

// File: rtl/ulm_break_det.sv
module ulm_break_det #(
    parameter int FL_W = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level,
    input  logic            level_q,
    input  logic            fall,
    input  logic            rise,
    input  logic [FL_W-1:0] frame_len,
    output logic            break_pulse
);

    localparam logic [FL_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic            active;
        logic [FL_W-1:0] cnt;
        logic            brk;
    } brk_t;

    brk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.brk = 1'b0;
        if (fall) begin
            s_d.active = 1'b1;
            s_d.cnt    = FL_W'(1);
        end else if (s_q.active) begin
            if (rise) begin
                s_d.brk    = (s_q.cnt >= frame_len);
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else if (!level && s_q.cnt != CNT_MAX) begin
                s_d.cnt = s_q.cnt + FL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign break_pulse = s_q.brk;

    AST_BRK_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.brk |=> !s_q.brk); // R3

    AST_BRK_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.brk |-> level_q); // R3

    AST_LOW_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !level && !fall && !rise && s_q.cnt == CNT_MAX)
        |=> (s_q.cnt == CNT_MAX)); // R10

endmodule

// File: rtl/ulm_idle_det.sv
module ulm_idle_det #(
    parameter int FL_W = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level,
    input  logic            level_q,
    input  logic [FL_W-1:0] frame_len,
    output logic            idle_pulse
);

    localparam logic [FL_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic            run;
        logic [FL_W-1:0] cnt;
        logic            idle;
    } idle_t;

    idle_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.idle = 1'b0;
        if (!level) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (!s_q.run) begin
            s_d.run = 1'b1;
            s_d.cnt = FL_W'(1);
        end else if (s_q.cnt >= frame_len) begin
            s_d.idle = 1'b1;
            s_d.cnt  = FL_W'(1);
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + FL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idle_pulse = s_q.idle;

    AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idle |-> level_q); // R8

    AST_IDLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.idle && frame_len >= FL_W'(2)) |=> !s_q.idle); // R7

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor
    import uart_lm_pkg::*;
#(
    parameter int BW_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    input  logic                  invert_en,
    input  logic [BW_W-1:0]       bit_width,
    input  logic [DATA_CNT_W-1:0] data_bits,
    input  logic                  parity_en,
    input  logic [1:0]            stop_len,
    output logic                  break_pulse,
    output logic                  idle_pulse
);

    localparam int FL_W = BW_W + HALF_UNITS_W;

    logic [FL_W-1:0] frame_len;
    logic            level, level_q, fall, rise;

    ulm_frame_len #(.BW_W(BW_W), .FL_W(FL_W)) frame_len_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_width (bit_width),
        .data_bits (data_bits),
        .parity_en (parity_en),
        .stop_len  (stop_len),
        .frame_len (frame_len)
    );

    ulm_line_cond line_cond_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .invert_en (invert_en),
        .level     (level),
        .level_q   (level_q),
        .fall      (fall),
        .rise      (rise)
    );

    ulm_break_det #(.FL_W(FL_W)) break_det_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .level_q     (level_q),
        .fall        (fall),
        .rise        (rise),
        .frame_len   (frame_len),
        .break_pulse (break_pulse)
    );

    ulm_idle_det #(.FL_W(FL_W)) idle_det_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_q    (level_q),
        .frame_len  (frame_len),
        .idle_pulse (idle_pulse)
    );

endmodule

// File: tb/uart_line_monitor_tb_top.sv
module uart_line_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BW_W       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       invert_en = 1'b0;
    logic [BW_W-1:0] bit_width = 4'd3;
    logic [3:0] data_bits = 4'd5;
    logic       parity_en = 1'b0;
    logic [1:0] stop_len = 2'd2;
    logic       break_pulse, idle_pulse;

    int errors = 0;
    int checks = 0;
    int span   = 21;
    bit inv    = 1'b0;
    bit brk_s, idl_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_line_monitor #(.BW_W(BW_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .invert_en   (invert_en),
        .bit_width   (bit_width),
        .data_bits   (data_bits),
        .parity_en   (parity_en),
        .stop_len    (stop_len),
        .break_pulse (break_pulse),
        .idle_pulse  (idle_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one logical level for one sample, then read the result of that sample.
    task automatic tick(input bit v);
        line_in = v ^ inv;
        @(negedge clk);
        brk_s = break_pulse;
        idl_s = idle_pulse;
    endtask

    task automatic set_cfg(input int bw, input int db, input bit par, input int stp,
                           input int f_exp);
        bit_width = BW_W'(bw);
        data_bits = 4'(db);
        parity_en = par;
        stop_len  = 2'(stp);
        span      = f_exp;
        for (int i = 0; i < 3; i++) tick(1'b1);
    endtask

    task automatic test_reset;
        int brk_cnt = 0;
        line_in = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        check(break_pulse == 1'b0 && idle_pulse == 1'b0, "R1 reset outputs",
              {30'd0, break_pulse, idle_pulse}, 0);
        rst_n = 1'b1;
        tick(1'b0);
        check(brk_s == 1'b0 && idl_s == 1'b0, "R1 first cycle after reset",
              {30'd0, brk_s, idl_s}, 0);
        for (int i = 0; i < 40; i++) begin
            tick(1'b0);
            brk_cnt += int'(brk_s);
        end
        tick(1'b1);
        brk_cnt += int'(brk_s);
        tick(1'b1);
        brk_cnt += int'(brk_s);
        check(brk_cnt == 0, "R5 low from reset gives no break", brk_cnt, 0);
    endtask

    // One low sample, then a high run of n spans; idle expected at k = F, 2F, ...
    task automatic idle_run(input int n, input string tag);
        int first = -1;
        int cnt = 0;
        int bad = 0;
        tick(1'b0);
        for (int k = 0; k <= n * span; k++) begin
            bit exp_i;
            tick(1'b1);
            exp_i = (k > 0) && (k % span == 0);
            if (idl_s) begin
                cnt++;
                if (first < 0) first = k;
            end
            if (idl_s != exp_i) bad++;
        end
        check(first == span, {tag, " R6 R2 first idle index"}, first, span);
        check(cnt == n, {tag, " R7 idle count"}, cnt, n);
        check(bad == 0, {tag, " R7 idle misplaced"}, bad, 0);
    endtask

    // High sample, low run of len samples, then return high.
    task automatic brk_run(input int len, input bit exp_b, input string tag);
        int early = 0;
        int idl = 0;
        tick(1'b1);
        for (int i = 0; i < len; i++) begin
            tick(1'b0);
            early += int'(brk_s);
            idl   += int'(idl_s);
        end
        check(early == 0 && idl == 0, {tag, " R8 no strobes while low"}, early + idl, 0);
        tick(1'b1);
        check(brk_s == exp_b, exp_b ? {tag, " R3 break on return"} : {tag, " R4 no break"},
              int'(brk_s), int'(exp_b));
        tick(1'b1);
        check(brk_s == 1'b0, {tag, " R3 break one cycle"}, int'(brk_s), 0);
    endtask

    task automatic idle_cancel(input string tag);
        int cnt = 0;
        tick(1'b0);
        for (int k = 0; k < span - 1; k++) begin
            tick(1'b1);
            cnt += int'(idl_s);
        end
        tick(1'b0);
        cnt += int'(idl_s);
        for (int k = 0; k < span; k++) begin
            tick(1'b1);
            cnt += int'(idl_s);
        end
        check(cnt == 0, {tag, " R8 cancelled span no idle"}, cnt, 0);
        tick(1'b1);
        check(idl_s == 1'b1, {tag, " R8 restarted span idle"}, int'(idl_s), 1);
    endtask

    initial begin
        test_reset();
        set_cfg(3, 5, 1'b0, 2, 21);
        idle_run(3, "cfgA");
        brk_run(20, 1'b0, "cfgA F-1");
        brk_run(21, 1'b1, "cfgA F");
        brk_run(22, 1'b1, "cfgA F+1");
        idle_cancel("cfgA");
        set_cfg(3, 5, 1'b1, 1, 23);
        idle_run(2, "cfgB");
        brk_run(22, 1'b0, "cfgB F-1");
        brk_run(23, 1'b1, "cfgB F");
        set_cfg(5, 8, 1'b1, 3, 58);
        idle_run(2, "cfgC");
        set_cfg(15, 9, 1'b1, 0, 165);
        idle_run(2, "cfgD");
        set_cfg(1, 7, 1'b0, 1, 9);
        idle_run(4, "cfgE odd half");
        brk_run(1500, 1'b1, "cfgE R10 saturated");
        // Inversion: logical levels stay the same, the pin carries their complement.
        set_cfg(3, 5, 1'b0, 2, 21);
        inv = 1'b1;
        invert_en = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b1);
        brk_run(20, 1'b0, "R9 inverted F-1");
        brk_run(21, 1'b1, "R9 inverted F");
        idle_run(2, "R9 inverted");
        idle_cancel("R9 inverted");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule